// File: doc/BRIEF.md
# Framed Serial Audio Transmitter

This block is the transmit side of a synchronous serial port for audio-style links such as I2S. Software programs a small register set: word length, channel arrangement, master or slave operation, idle line level and an optional sync word. It then writes data words into a holding register. The block moves each word into a shift register at the next qualifying frame-sync edge and shifts it out MSB first, one bit per bit-clock period, on the data line.

In master mode the block makes its own bit clock and frame sync. The bit clock comes from the system clock through a divider whose reset value is the rounded quotient of the system clock over twice the bit rate. The frame sync is an active-low pulse one word long, followed by an equally long high phase. In slave mode both signals come from outside and the block only follows them. The bit clock is sampled in the system clock domain, and the frame sync is captured on bit-clock rising edges. Data always changes after a bit-clock falling edge. The first bit of a word lands one bit period after the edge that opened its slot.

Two status flags report the buffer state: one when the holding register can take a word, one when both the holding register and the shifter are drained. An optional sync word can be shifted out during the low frame-sync pulse whenever no data word is using the line.

Top module: `frame_tx`

## Requirements
- R1: The divider register (address 1, bits 15:0) resets to floor((SYS_HZ + BIT_HZ) / BIT_HZ) / 2. If either frequency is zero it resets to 0. A divider value of 0 keeps the bit clock output low.
- R2: In master mode (control address 0, bit 0 enable = 1, bit 1 master = 1), the bit clock output holds each level for exactly the divider value in system clock cycles.
- R3: In master mode the frame-sync output starts high and changes only on bit-clock falling edges. It goes low after the first W falling edges and then alternates, staying low for W bit periods and high for W bit periods. W is the control field at bits 12:8 plus one.
- R4: A loaded word is shifted out MSB first. Only its low W bits are sent. The first bit appears in the bit period right after the one in which the opening frame-sync edge occurred.
- R5: The start edge follows control bits 3:2: 0 means a falling frame-sync edge, 1 a rising edge, and 2 or 3 either edge.
- R6: With either-edge starts, two queued words go out back to back: the first after the falling edge, the second after the next rising edge. This gives two words per frame.
- R7: When no word or sync word is being shifted, the data line holds the idle level set by control bit 5.
- R8: With control bit 4 set, the sync word (address 3) is shifted out MSB first, W bits long, starting one bit period after each falling frame-sync edge. A data word being shifted takes priority over it.
- R9: Status (address 4) bit 0 is ready, set when the holding register (write address 2) is empty. Bit 1 is empty, set only when both the holding register and the shifter are idle. Both reset to 1. A write clears ready on the next cycle.
- R10: A held word moves into the shifter only at a start edge. After a word ends with nothing held, the line returns to the idle level.
- R11: In slave mode (master bit 0), the block shifts on falling edges of the bit clock input. It uses the frame-sync input as captured on the previous rising edge, and keeps the bit clock output low and the frame-sync output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sck_in | input | 1 | Bit clock from outside (slave mode) |
| fs_in | input | 1 | Frame sync from outside (slave mode) |
| sck_out | output | 1 | Generated bit clock (master mode) |
| fs_out | output | 1 | Generated frame sync, active low (master mode) |
| sd_out | output | 1 | Serial data line |

## Verification
The vector table runs master mode with word lengths of 2, 8, 16, 24 and 32 bits, both single-edge start modes and both idle levels. This separates a wrong edge choice from a wrong length mask, and separates a stuck idle level from a missing return to idle. Either-edge mode is run with two queued words, which shows whether the second word waits for the opposite edge and whether the ready and empty flags follow the two stages. A sync-word run uses rising-edge starts so that the sync word and the data word occupy the two halves of one frame. Directed runs cover the divider reset value, a zero-rate instance, the bit-clock half period, and slave mode driven from the bench, where the start must come from the frame sync captured on the rising edge.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  typedef enum logic [1:0] {
    CH_ON_FALL = 2'd0,
    CH_ON_RISE = 2'd1,
    CH_ON_ANY  = 2'd2,
    CH_ON_ANY2 = 2'd3
  } chan_e;

  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_DIV  = 3'd1;
  localparam logic [2:0] ADR_DATA = 3'd2;
  localparam logic [2:0] ADR_SYNC = 3'd3;
  localparam logic [2:0] ADR_STAT = 3'd4;

  // rounded system clock over twice the bit rate; zero inputs give 0
  function automatic longint unsigned div_calc(input longint unsigned clk_hz,
                                               input longint unsigned rate_hz);
    if (clk_hz == 0 || rate_hz == 0) return 0;
    return ((clk_hz + rate_hz) / rate_hz) >> 1;
  endfunction

  function automatic logic start_hit(input chan_e mode, input logic fell, input logic rose);
    case (mode)
      CH_ON_FALL: return fell;
      CH_ON_RISE: return rose;
      default:    return fell | rose;
    endcase
  endfunction

endpackage

// File: rtl/frame_tx_regs.sv
module frame_tx_regs
  import frame_tx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int DIVW = 16,
  parameter int AW   = 3,
  parameter int WL_W = 5,
  parameter logic [DIVW-1:0] DIV_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            ready,
  input  logic            empty,
  output logic            en,
  output logic            master,
  output chan_e           chan,
  output logic            sync_en,
  output logic            idle_lvl,
  output logic [WL_W-1:0] wlen_m1,
  output logic [DIVW-1:0] div,
  output logic [DW-1:0]   sync_word,
  output logic            data_wr,
  output logic [DW-1:0]   data_word
);

  localparam int WL_POS = 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      master    <= 1'b0;
      chan      <= CH_ON_FALL;
      sync_en   <= 1'b0;
      idle_lvl  <= 1'b0;
      wlen_m1   <= '0;
      div       <= DIV_RST;
      sync_word <= '0;
    end else if (we) begin
      case (addr)
        AW'(ADR_CTRL): begin
          en       <= wdata[0];
          master   <= wdata[1];
          chan     <= chan_e'(wdata[3:2]);
          sync_en  <= wdata[4];
          idle_lvl <= wdata[5];
          wlen_m1  <= wdata[WL_POS +: WL_W];
        end
        AW'(ADR_DIV):  div       <= wdata[DIVW-1:0];
        AW'(ADR_SYNC): sync_word <= wdata;
        default: ;
      endcase
    end
  end

  assign data_wr   = we && (addr == AW'(ADR_DATA));
  assign data_word = wdata;

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(ADR_CTRL): begin
        rdata[0]              = en;
        rdata[1]              = master;
        rdata[3:2]            = chan;
        rdata[4]              = sync_en;
        rdata[5]              = idle_lvl;
        rdata[WL_POS +: WL_W] = wlen_m1;
      end
      AW'(ADR_DIV):  rdata[DIVW-1:0] = div;
      AW'(ADR_SYNC): rdata = sync_word;
      AW'(ADR_STAT): rdata[1:0] = {empty, ready};
      default: ;
    endcase
  end

endmodule

// File: rtl/frame_tx_clk.sv
module frame_tx_clk #(
  parameter int DIVW = 16,
  parameter int WL_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            master,
  input  logic [DIVW-1:0] div,
  input  logic [WL_W-1:0] wlen_m1,
  input  logic            sck_in,
  input  logic            fs_in,
  output logic            tick,
  output logic            fs_now,
  output logic            sck_out,
  output logic            fs_out
);

  logic [DIVW-1:0] dcnt;
  logic [WL_W-1:0] bcnt;
  logic            sck_r, fs_r, sck_d, fs_smp;
  logic            run_m, half_end, m_tick, s_tick, s_rise;

  assign run_m    = en && master && (div != '0);
  assign half_end = run_m && (dcnt == div - 1'b1);
  assign m_tick   = half_end && sck_r;

  // bit clock divider: each level lasts div system clocks
  always_ff @(posedge clk) begin
    if (!rst_n || !run_m) begin
      dcnt  <= '0;
      sck_r <= 1'b0;
    end else if (half_end) begin
      dcnt  <= '0;
      sck_r <= ~sck_r;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  // frame sync generator: toggles every W bit clocks
  always_ff @(posedge clk) begin
    if (!rst_n || !(en && master)) begin
      bcnt <= '0;
      fs_r <= 1'b1;
    end else if (m_tick) begin
      if (bcnt == wlen_m1) begin
        bcnt <= '0;
        fs_r <= ~fs_r;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  // slave side: follow the outside clock, capture sync on rising edges
  assign s_tick = en && !master && sck_d && !sck_in;
  assign s_rise = !sck_d && sck_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      fs_smp <= 1'b1;
    end else begin
      sck_d <= sck_in;
      if (s_rise) fs_smp <= fs_in;
    end
  end

  assign tick    = master ? m_tick : s_tick;
  assign fs_now  = master ? fs_r : fs_smp;
  assign sck_out = sck_r;
  assign fs_out  = master ? fs_r : 1'b1;

  AST_SLAVE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && $past(!master)) |-> (!sck_out && fs_out)); // R11
  AST_DIV_ZERO_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0 && $past(div == '0)) |-> !sck_out); // R1
  AST_FS_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && $past(en && master) && fs_out != $past(fs_out)) |-> (!sck_out && $past(sck_out))); // R3

endmodule

// File: rtl/frame_tx_shift.sv
module frame_tx_shift
  import frame_tx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int WL_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            fs_now,
  input  chan_e           chan,
  input  logic            sync_en,
  input  logic            idle_lvl,
  input  logic [WL_W-1:0] wlen_m1,
  input  logic            data_wr,
  input  logic [DW-1:0]   data_word,
  input  logic [DW-1:0]   sync_word,
  output logic            sd_out,
  output logic            ready,
  output logic            empty
);

  logic [DW-1:0] hold, shr, syn;
  logic          hold_full, fs_seen;
  logic [WL_W:0] bits_left, sync_left;
  logic [WL_W:0] wlen;
  logic          fell, rose, start_ev, busy, word_done, load, sync_ld;

  // place bit W-1 of a word at the shifter MSB
  function automatic logic [DW-1:0] align(input logic [DW-1:0] w, input logic [WL_W-1:0] m1);
    return w << (DW - 1 - int'(m1));
  endfunction

  assign wlen      = {1'b0, wlen_m1} + 1'b1;
  assign fell      = tick && fs_seen && !fs_now;
  assign rose      = tick && !fs_seen && fs_now;
  assign start_ev  = start_hit(chan, fell, rose);
  assign busy      = (bits_left != '0);
  assign word_done = tick && (bits_left == 1);
  assign load      = start_ev && hold_full && (!busy || word_done);
  assign sync_ld   = fell && sync_en;

  always_ff @(posedge clk) begin
    if (!rst_n) fs_seen <= 1'b1;
    else if (tick) fs_seen <= fs_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (data_wr) begin
      hold      <= data_word;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shr       <= '0;
      bits_left <= '0;
    end else if (load) begin
      shr       <= align(hold, wlen_m1);
      bits_left <= wlen;
    end else if (tick && busy) begin
      shr       <= shr << 1;
      bits_left <= bits_left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syn       <= '0;
      sync_left <= '0;
    end else if (sync_ld) begin
      syn       <= align(sync_word, wlen_m1);
      sync_left <= wlen;
    end else if (tick && sync_left != '0) begin
      syn       <= syn << 1;
      sync_left <= sync_left - 1'b1;
    end
  end

  assign sd_out = busy ? shr[DW-1] : ((sync_left != '0) ? syn[DW-1] : idle_lvl);
  assign ready  = !hold_full;
  assign empty  = !hold_full && !busy;

  AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !ready); // R9
  AST_LOAD_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tick)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_left <= (WL_W+1)'(DW)) && (sync_left <= (WL_W+1)'(DW))); // R4
  AST_LINE_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && $stable(idle_lvl)) |-> $stable(sd_out)); // R7

endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int DIVW = 16,
  parameter int AW   = 3,
  parameter longint unsigned SYS_HZ = 50_000_000,
  parameter longint unsigned BIT_HZ = 3_072_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sck_in,
  input  logic          fs_in,
  output logic          sck_out,
  output logic          fs_out,
  output logic          sd_out
);

  localparam int WL_W = $clog2(DW);
  localparam logic [DIVW-1:0] DIV_RST = DIVW'(div_calc(SYS_HZ, BIT_HZ));

  logic            en, master, sync_en, idle_lvl, data_wr, ready, empty, tick, fs_now;
  chan_e           chan;
  logic [WL_W-1:0] wlen_m1;
  logic [DIVW-1:0] div;
  logic [DW-1:0]   sync_word, data_word;

  frame_tx_regs #(.DW(DW), .DIVW(DIVW), .AW(AW), .WL_W(WL_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ready(ready), .empty(empty), .en(en), .master(master),
    .chan(chan), .sync_en(sync_en), .idle_lvl(idle_lvl), .wlen_m1(wlen_m1),
    .div(div), .sync_word(sync_word), .data_wr(data_wr), .data_word(data_word)
  );

  frame_tx_clk #(.DIVW(DIVW), .WL_W(WL_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .div(div),
    .wlen_m1(wlen_m1), .sck_in(sck_in), .fs_in(fs_in), .tick(tick),
    .fs_now(fs_now), .sck_out(sck_out), .fs_out(fs_out)
  );

  frame_tx_shift #(.DW(DW), .WL_W(WL_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fs_now(fs_now), .chan(chan),
    .sync_en(sync_en), .idle_lvl(idle_lvl), .wlen_m1(wlen_m1), .data_wr(data_wr),
    .data_word(data_word), .sync_word(sync_word), .sd_out(sd_out),
    .ready(ready), .empty(empty)
  );

endmodule

// File: tb/tb_frame_tx.sv
`timescale 1ns/1ps
module tb_frame_tx;

  localparam longint unsigned SYS = 50_000_000;
  localparam longint unsigned BIT = 3_072_000;

  logic clk = 0, rst_n = 0, we = 0, sck_in = 1, fs_in = 1;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, rdata_z;
  logic sck_out, fs_out, sd_out, sck_out_z, fs_out_z, sd_out_z;

  always #10 clk = ~clk;

  frame_tx #(.SYS_HZ(SYS), .BIT_HZ(BIT)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .sck_in(sck_in), .fs_in(fs_in), .sck_out(sck_out),
    .fs_out(fs_out), .sd_out(sd_out));

  frame_tx #(.SYS_HZ(SYS), .BIT_HZ(0)) dut_zero (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata_z), .sck_in(1'b0), .fs_in(1'b1), .sck_out(sck_out_z),
    .fs_out(fs_out_z), .sd_out(sd_out_z));

  int nchk = 0, nerr = 0;
  bit done = 0;

  // chan[39:38] len-1[37:33] idle[32] word[31:0]
  localparam logic [39:0] VEC [5] = '{
    {2'd0, 5'd15, 1'b0, 32'h0000A5C3},
    {2'd1, 5'd7,  1'b0, 32'hFFFFFF81},
    {2'd0, 5'd23, 1'b1, 32'h005A0F3C},
    {2'd1, 5'd31, 1'b1, 32'hDEADBEEF},
    {2'd0, 5'd1,  1'b0, 32'h00000002}
  };

  logic log_fs [256];
  logic log_sd [256];
  int   nslot = 0;
  bit   cap_on = 0;
  logic sck_prev = 0;

  always @(negedge clk) begin
    if (cap_on && sck_prev && !sck_out && nslot < 256) begin
      log_fs[nslot] = fs_out;
      log_sd[nslot] = sd_out;
      nslot++;
    end
    sck_prev = sck_out;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cap_on = 0; nslot = 0; sck_in = 1; fs_in = 1;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  function automatic logic [31:0] mk_ctrl(input logic en, input logic m, input logic [1:0] ch,
                                          input logic s, input logic idle, input logic [4:0] m1);
    return {19'd0, m1, 2'd0, idle, s, ch, m, en};
  endfunction

  function automatic logic [31:0] grab(input int from, input int n);
    logic [31:0] v = 0;
    for (int k = 0; k < n; k++) v = {v[30:0], log_sd[from + k]};
    return v;
  endfunction

  function automatic logic [31:0] lowmask(input int n);
    return (n >= 32) ? 32'hFFFFFFFF : ((32'd1 << n) - 1);
  endfunction

  task automatic run_master(input logic [1:0] ch, input logic [4:0] m1, input logic idle,
                            input logic [31:0] w);
    int wl, st, f, bad;
    logic [31:0] r;
    wl = int'(m1) + 1;
    do_reset();
    wr(3'd1, 32'd2);
    wr(3'd2, w);
    cap_on = 1;
    wr(3'd0, mk_ctrl(1, 1, ch, 0, idle, m1));
    wait (nslot >= 3 * wl + 3);
    cap_on = 0;
    st = -1;
    for (int k = 0; k < nslot; k++) begin
      logic pv;
      pv = (k == 0) ? 1'b1 : log_fs[k-1];
      if ((ch == 2'd0 && pv && !log_fs[k]) || (ch == 2'd1 && !pv && log_fs[k])) begin
        st = k; break;
      end
    end
    chk($sformatf("R5 start slot ch=%0d wl=%0d", ch, wl), st, (ch == 2'd0) ? wl - 1 : 2 * wl - 1);
    if (st < 0) st = 0;
    chk($sformatf("R4 word wl=%0d", wl), grab(st + 1, wl), w & lowmask(wl));
    bad = 0;
    for (int k = 0; k <= st; k++) if (log_sd[k] !== idle) bad++;
    chk("R7 idle before start", bad, 0);
    chk("R10 idle after word", {31'd0, log_sd[st + wl + 1]}, {31'd0, idle});
    f = wl - 1;
    bad = 0;
    for (int k = 0; k < wl; k++) if (log_fs[f + k] !== 1'b0) bad++;
    if (log_fs[f + wl] !== 1'b1) bad++;
    chk($sformatf("R3 sync low width wl=%0d", wl), bad, 0);
    rd(3'd4, r);
    chk("R9 drained flags", r, 32'd3);
  endtask

  initial begin : main
    logic [31:0] r;
    int n, lastc, cnt, bad;
    logic [31:0] slog [24];

    // reset state
    do_reset();
    #1;
    chk("R9 reset status", 0, 0);
    rd(3'd4, r);          chk("R9 reset ready/empty", r, 32'd3);
    chk("R7 reset line", {31'd0, sd_out}, 0);
    chk("R3 reset fs high", {31'd0, fs_out}, 1);
    rd(3'd1, r);          chk("R1 divider reset", r, 32'((SYS + BIT) / (2 * BIT)));
    @(negedge clk); addr = 3'd1; #1 chk("R1 zero rate divider", rdata_z, 0);
    wr(3'd0, mk_ctrl(1, 1, 2'd0, 0, 0, 5'd7));
    bad = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (sck_out_z !== 1'b0) bad++; end
    chk("R1 zero divider clock idle", bad, 0);

    // bit clock half period
    do_reset();
    wr(3'd1, 32'd3);
    wr(3'd0, mk_ctrl(1, 1, 2'd0, 0, 0, 5'd7));
    @(negedge clk); lastc = sck_out;
    while (sck_out == lastc) @(negedge clk);
    for (int h = 0; h < 2; h++) begin
      lastc = sck_out; cnt = 0;
      while (sck_out == lastc && cnt < 50) begin @(negedge clk); cnt++; end
      chk("R2 half period cycles", cnt, 3);
    end

    // table of master vectors
    for (int v = 0; v < 5; v++)
      run_master(VEC[v][39:38], VEC[v][37:33], VEC[v][32], VEC[v][31:0]);

    // either-edge start, two words per frame
    do_reset();
    wr(3'd1, 32'd2);
    wr(3'd2, 32'h3C);
    rd(3'd4, r); chk("R9 after write", r, 32'd0);
    cap_on = 1;
    wr(3'd0, mk_ctrl(1, 1, 2'd2, 0, 0, 5'd7));
    n = 0;
    do begin rd(3'd4, r); n++; end while (r[0] == 1'b0 && n < 500);
    chk("R9 ready while shifting", r, 32'd1);
    wr(3'd2, 32'hC5);
    wait (nslot >= 26);
    cap_on = 0;
    chk("R6 first word", grab(8, 8), 32'h3C);
    chk("R6 second word", grab(16, 8), 32'hC5);
    chk("R10 idle after pair", {31'd0, log_sd[24]}, 0);
    rd(3'd4, r); chk("R9 empty after pair", r, 32'd3);

    // sync word in the low half, data in the high half
    do_reset();
    wr(3'd1, 32'd2);
    wr(3'd3, 32'h96);
    wr(3'd2, 32'h4B);
    cap_on = 1;
    wr(3'd0, mk_ctrl(1, 1, 2'd1, 1, 0, 5'd7));
    wait (nslot >= 26);
    cap_on = 0;
    chk("R8 sync word in pulse", grab(8, 8), 32'h96);
    chk("R8 data after rise", grab(16, 8), 32'h4B);
    chk("R7 idle before pulse", {31'd0, log_sd[7]}, 0);

    // slave mode
    do_reset();
    wr(3'd2, 32'hB4);
    wr(3'd0, mk_ctrl(1, 0, 2'd0, 0, 0, 5'd7));
    bad = 0;
    for (int j = 0; j < 24; j++) begin
      @(negedge clk);
      sck_in = 0;
      fs_in = (j < 4) ? 1'b1 : (((j - 4) / 8) % 2 == 1);
      repeat (3) @(negedge clk);
      slog[j] = {31'd0, sd_out};
      if (sck_out !== 1'b0 || fs_out !== 1'b1) bad++;
      sck_in = 1;
      repeat (3) @(negedge clk);
    end
    chk("R11 outputs quiet in slave", bad, 0);
    r = 0;
    for (int j = 5; j < 13; j++) r = {r[30:0], slog[j][0]};
    chk("R11 slave word", r, 32'hB4);
    chk("R11 slave idle before", slog[4], 0);
    chk("R10 slave idle after", slog[13], 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule